// File: doc/BRIEF.md
# Serial Transmit Cycle Controller

This block decides when a Manchester-coded bus terminal may shift out a message, keeps shifting going word after word, and stops it. A request to transmit comes from an active-low encoder enable. That enable only counts while an active-low channel select is also low. A granted request starts a transmit cycle only on a high-to-low transition of the encoder shift clock, so the first bit lines up with the encoder's bit timing. While the cycle runs, the block holds its send-data output high.

A message ends normally when the encoder signals a word boundary while the gated enable is inactive. A hard time limit also guards every message. With the default 12 MHz clock the limit is 9216 clock cycles (768 µs). When a message reaches the limit, shifting is cut off at once and a fail-safe flag latches. While that flag is set, no new message can start. A clear input or the master reset removes the flag.

The encoder, the holding registers and the line driver sit outside this block. The block only sees the shift clock as a level and a one-cycle word-boundary strobe.

Top module: `txc_ctrl`

## Requirements
- R1: While `mrst_n` is low, `send_data` and `fail_safe` are both 0. The reset acts without waiting for a clock edge.
- R2: `shift_clk` is sampled on every rising edge of `clk`. A falling transition is an edge at which `shift_clk` is 0 and was 1 at the previous edge. With the gated request present, `send_data` goes to 1 on the clock edge that sees the falling transition, and not before.
- R3: A request exists only when both `chan_sel_n` and `enc_en_n` are 0. With `chan_sel_n` at 1, a low `enc_en_n` never starts a message.
- R4: Once started, `send_data` stays at 1 through word boundaries while the gated request is present. A `word_end` pulse seen while `chan_sel_n` or `enc_en_n` is 1 makes `send_data` go to 0 on that edge.
- R5: If `send_data` has been 1 for WD_LIMIT consecutive cycles (CLK_HZ/1e6 × LIMIT_US, 9216 by default), it goes to 0 and `fail_safe` goes to 1 on the same edge.
- R6: While `fail_safe` is 1, no new message starts, whatever the request and shift clock do.
- R7: `fs_clear` high at a clock edge clears `fail_safe` on that edge, unless an abort sets it on the same edge.
- R8: Pulling `mrst_n` low clears a set `fail_safe` and stops any message.
- R9: The time limit counts from 0 for every message, so a message that ends normally leaves no time charged to the next one.
- R10: While no message is running, `word_end` pulses and shift-clock activity without a request leave `send_data` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz nominal) |
| mrst_n | input | 1 | Master reset, active low, asynchronous |
| shift_clk | input | 1 | Encoder shift clock, sampled as a level |
| word_end | input | 1 | One-cycle strobe at each encoder word boundary |
| chan_sel_n | input | 1 | Channel select, active low; enables the request |
| enc_en_n | input | 1 | Encoder enable request, active low |
| fs_clear | input | 1 | Clears the fail-safe flag when high |
| send_data | output | 1 | High while transmit shifting is in progress |
| fail_safe | output | 1 | Latched flag: a message ran past the time limit |

## Verification
The hardest state to reach from the ports is an abort exactly at the limit. It needs one unbroken message of 9216 cycles, with word boundaries arriving while the request stays active. The stimulus holds the request low and fires random `word_end` pulses for the whole span, then counts the high cycles of `send_data` against the limit. It also runs two back-to-back messages whose total exceeds the limit, to show that the count restarts for each message. Both ways of clearing the flag follow a real abort, and a cycle-level bench model is compared on every clock through random shift-clock rates and request patterns.

// File: rtl/txc_pkg.sv
package txc_pkg;

  typedef enum logic [0:0] {
    TXC_IDLE  = 1'b0,
    TXC_SHIFT = 1'b1
  } txc_state_e;

  // Length of the message limit in system clock cycles.
  function automatic int wd_cycles(input int clk_hz, input int limit_us);
    return (clk_hz / 1_000_000) * limit_us;
  endfunction

  // Counter width that can hold 0 .. n-1.
  function automatic int cnt_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/txc_fall_detect.sv
module txc_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign fall = level_q & ~level;

endmodule

// File: rtl/txc_req_gate.sv
module txc_req_gate (
  input  logic chan_sel_n,
  input  logic enc_en_n,
  input  logic fail_safe,
  input  logic sc_fall,
  input  logic word_end,
  output logic start_ok,
  output logic stop_ok
);
  logic req_active;

  assign req_active = ~chan_sel_n & ~enc_en_n;
  assign start_ok   = sc_fall & req_active & ~fail_safe;
  assign stop_ok    = word_end & ~req_active;

endmodule

// File: rtl/txc_watchdog.sv
module txc_watchdog #(
  parameter int LIMIT = 9216,
  parameter int CW    = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt;

  assign expire = run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (!expire) cnt <= cnt + 1'b1;
  end

  AST_WD_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0)); // R9

endmodule

// File: rtl/txc_seq_fsm.sv
module txc_seq_fsm
  import txc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_ok,
  input  logic stop_ok,
  input  logic expire,
  input  logic fs_clear,
  output logic send_data,
  output logic fail_safe,
  output logic abort_evt
);
  txc_state_e state_q, state_d;
  logic       fs_q, fs_d;

  always_comb begin
    state_d   = state_q;
    abort_evt = 1'b0;
    case (state_q)
      TXC_IDLE:  if (start_ok) state_d = TXC_SHIFT;
      TXC_SHIFT: begin
        if (expire) begin
          state_d   = TXC_IDLE;
          abort_evt = 1'b1;
        end else if (stop_ok) begin
          state_d = TXC_IDLE;
        end
      end
      default:   state_d = TXC_IDLE;
    endcase
  end

  always_comb begin
    if (abort_evt)     fs_d = 1'b1;
    else if (fs_clear) fs_d = 1'b0;
    else               fs_d = fs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXC_IDLE;
      fs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fs_q    <= fs_d;
    end
  end

  assign send_data = (state_q == TXC_SHIFT);
  assign fail_safe = fs_q;

endmodule

// File: rtl/txc_ctrl.sv
module txc_ctrl #(
  parameter int CLK_HZ   = 12_000_000,
  parameter int LIMIT_US = 768
) (
  input  logic clk,
  input  logic mrst_n,
  input  logic shift_clk,
  input  logic word_end,
  input  logic chan_sel_n,
  input  logic enc_en_n,
  input  logic fs_clear,
  output logic send_data,
  output logic fail_safe
);
  localparam int WD_LIMIT = txc_pkg::wd_cycles(CLK_HZ, LIMIT_US);
  localparam int WD_CW    = txc_pkg::cnt_bits(WD_LIMIT);

  logic sc_fall;
  logic start_ok;
  logic stop_ok;
  logic wd_expire;
  logic abort_evt;

  txc_fall_detect u_fall (
    .clk   (clk),
    .rst_n (mrst_n),
    .level (shift_clk),
    .fall  (sc_fall)
  );

  txc_req_gate u_gate (
    .chan_sel_n (chan_sel_n),
    .enc_en_n   (enc_en_n),
    .fail_safe  (fail_safe),
    .sc_fall    (sc_fall),
    .word_end   (word_end),
    .start_ok   (start_ok),
    .stop_ok    (stop_ok)
  );

  txc_watchdog #(
    .LIMIT (WD_LIMIT),
    .CW    (WD_CW)
  ) u_wd (
    .clk    (clk),
    .rst_n  (mrst_n),
    .run    (send_data),
    .expire (wd_expire)
  );

  txc_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (mrst_n),
    .start_ok  (start_ok),
    .stop_ok   (stop_ok),
    .expire    (wd_expire),
    .fs_clear  (fs_clear),
    .send_data (send_data),
    .fail_safe (fail_safe),
    .abort_evt (abort_evt)
  );

  AST_START_ON_FALL: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(send_data) |-> ($past(shift_clk, 2) && !$past(shift_clk))); // R2

  AST_CHAN_GATE: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(send_data) |-> $past(!chan_sel_n && !enc_en_n)); // R3

  AST_WORD_STOP: assert property (@(posedge clk) disable iff (!mrst_n)
    (send_data && word_end && (chan_sel_n || enc_en_n) && !wd_expire) |=> !send_data); // R4

  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!mrst_n)
    abort_evt |=> (fail_safe && !send_data)); // R5

  AST_FS_HOLDOFF: assert property (@(posedge clk) disable iff (!mrst_n)
    fail_safe |=> !$rose(send_data)); // R6

  AST_FS_CLEAR: assert property (@(posedge clk) disable iff (!mrst_n)
    (fs_clear && !wd_expire) |=> !fail_safe); // R7

  AST_FS_ONLY_ABORT: assert property (@(posedge clk) disable iff (!mrst_n)
    $rose(fail_safe) |-> $fell(send_data)); // R5

endmodule

// File: tb/txc_ctrl_test.sv
`timescale 1ns/1ps
module txc_ctrl_test;
  localparam int LIMIT = 12 * 768;

  logic clk = 1'b0;
  logic mrst_n, shift_clk, word_end, chan_sel_n, enc_en_n, fs_clear;
  logic send_data, fail_safe;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur = "R1";

  // bench model state
  bit m_send, m_fs, m_prev;
  int m_run;
  int sc_cnt = 0;
  int sc_half = 3;

  always #5 clk = ~clk;

  txc_ctrl uut (
    .clk(clk), .mrst_n(mrst_n), .shift_clk(shift_clk), .word_end(word_end),
    .chan_sel_n(chan_sel_n), .enc_en_n(enc_en_n), .fs_clear(fs_clear),
    .send_data(send_data), .fail_safe(fail_safe)
  );

  function automatic bit requested(input logic cs, input logic en);
    return (cs == 1'b0) && (en == 1'b0);
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // model of one clock edge, from the requirements
  task automatic model_step();
    bit fell;
    bit aborted;
    fell = m_prev && !shift_clk;
    aborted = 1'b0;
    if (!mrst_n) begin
      m_send = 0; m_fs = 0; m_prev = 0; m_run = 0;
      return;
    end
    if (m_send) begin
      m_run = m_run + 1;
      if (m_run == LIMIT) begin
        m_send = 0; aborted = 1'b1;
      end else if (word_end && !requested(chan_sel_n, enc_en_n)) begin
        m_send = 0;
      end
    end else if (fell && requested(chan_sel_n, enc_en_n) && !m_fs) begin
      m_send = 1; m_run = 0;
    end
    if (aborted) m_fs = 1;
    else if (fs_clear) m_fs = 0;
    m_prev = shift_clk;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    chk(cur, "model send_data", int'(send_data), int'(m_send));
    chk(cur, "model fail_safe", int'(fail_safe), int'(m_fs));
  endtask

  task automatic sc_adv();
    sc_cnt++;
    if (sc_cnt >= sc_half) begin
      sc_cnt = 0;
      shift_clk = ~shift_clk;
    end
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      sc_adv(); tick();
    end
  endtask

  task automatic wait_start();
    for (int i = 0; i < 40 && !send_data; i++) begin
      sc_adv(); tick();
    end
  endtask

  task automatic end_msg();
    enc_en_n = 1'b1; word_end = 1'b1; tick(); word_end = 1'b0;
  endtask

  initial begin
    int hi;
    void'($urandom(7741));
    mrst_n = 0; shift_clk = 0; word_end = 0; chan_sel_n = 1; enc_en_n = 1; fs_clear = 0;
    @(negedge clk);
    cur = "R1";
    run_cycles(3);
    chk("R1", "send_data in reset", int'(send_data), 0);
    chk("R1", "fail_safe in reset", int'(fail_safe), 0);
    mrst_n = 1;
    run_cycles(2);

    // R10: idle activity without a request
    cur = "R10";
    for (int i = 0; i < 40; i++) begin
      sc_adv(); word_end = (i % 7 == 0); tick();
      chk("R10", "idle send_data", int'(send_data), 0);
    end
    word_end = 0;

    // R3: enable low but channel not selected
    cur = "R3";
    enc_en_n = 0;
    for (int i = 0; i < 40; i++) begin
      sc_adv(); tick();
      chk("R3", "gated send_data", int'(send_data), 0);
    end

    // R2: start waits for a falling shift clock
    cur = "R2";
    shift_clk = 1; chan_sel_n = 0; sc_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2", "no start before fall", int'(send_data), 0);
    end
    shift_clk = 0; tick();
    chk("R2", "start on fall edge", int'(send_data), 1);

    // R4: continue through word ends, stop when request drops
    cur = "R4"; sc_half = 4;
    for (int i = 0; i < 30; i++) begin
      sc_adv(); word_end = (i == 15); tick();
      chk("R4", "shifting continues", int'(send_data), 1);
    end
    word_end = 0; enc_en_n = 1;
    run_cycles(5);
    chk("R4", "no stop without word end", int'(send_data), 1);
    word_end = 1; tick(); word_end = 0;
    chk("R4", "stop at word end", int'(send_data), 0);

    // R5: abort at exactly LIMIT cycles
    cur = "R5"; enc_en_n = 0;
    wait_start();
    hi = send_data ? 1 : 0;
    for (int i = 0; i < LIMIT + 100 && send_data; i++) begin
      sc_adv(); word_end = ($urandom % 32 == 0); tick();
      if (send_data) hi++;
    end
    word_end = 0;
    chk("R5", "send_data high cycles", hi, LIMIT);
    chk("R5", "fail_safe after abort", int'(fail_safe), 1);

    // R6: requests ignored while flag is set
    cur = "R6";
    for (int i = 0; i < 60; i++) begin
      sc_adv(); tick();
      chk("R6", "no start while fail_safe", int'(send_data), 0);
    end
    chk("R6", "flag still set", int'(fail_safe), 1);

    // R7: clear input
    cur = "R7"; enc_en_n = 1;
    fs_clear = 1; tick(); fs_clear = 0;
    chk("R7", "fail_safe cleared", int'(fail_safe), 0);
    enc_en_n = 0;
    wait_start();
    chk("R7", "start after clear", int'(send_data), 1);
    end_msg();

    // R9: two messages longer than the limit together
    cur = "R9";
    for (int k = 0; k < 2; k++) begin
      enc_en_n = 0;
      wait_start();
      run_cycles(6000);
      chk("R9", "still shifting", int'(send_data), 1);
      end_msg();
      chk("R9", "normal end", int'(send_data), 0);
    end
    chk("R9", "no fail_safe after reload", int'(fail_safe), 0);

    // R8: master reset clears the flag
    cur = "R8"; enc_en_n = 0;
    wait_start();
    run_cycles(LIMIT + 20);
    chk("R8", "fail_safe before reset", int'(fail_safe), 1);
    mrst_n = 0; tick();
    chk("R8", "fail_safe after reset", int'(fail_safe), 0);
    chk("R8", "send_data after reset", int'(send_data), 0);
    mrst_n = 1; enc_en_n = 1; tick();

    // random traffic against the model
    cur = "R4";
    for (int i = 0; i < 4000; i++) begin
      if (i % 200 == 0) sc_half = 2 + int'($urandom % 5);
      if ($urandom % 16 == 0) chan_sel_n = ($urandom % 4 == 0);
      if ($urandom % 12 == 0) enc_en_n = ~enc_en_n;
      word_end = ($urandom % 8 == 0);
      fs_clear = ($urandom % 64 == 0);
      sc_adv(); tick();
    end
    word_end = 0; fs_clear = 0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule